// File: doc/BRIEF.md
# Block-Lock Write Protection Unit

This block is the permission gate in front of a small serial nonvolatile memory. It receives the state of the write-protect pin, the stored protect-enable bit, the stored two-bit region lock level and the target byte address. From these it produces two write grants: one for status-register writes and one for array writes. It also holds the write-enable latch. Two opcodes set and clear the latch. Power-up reset clears it, and so does the end of any program cycle.

Array protection works in two parts. First, a lock level reserves the top quarter, the top half or the whole of the array. Second, a hardware pin can freeze the stored configuration. The pin acts only when the stored protect-enable bit is 1, and that bit is itself part of what the pin freezes, so it cannot be cleared while the pin is held low. A status-register write sequence that is still being clocked in is cancelled if the pin falls before chip select is released.

The grants are combinational. The enclosing controller samples them at the point where it commits a write. Framing, opcode extraction and nonvolatile cell timing belong to the surrounding logic.

Top module: `wp_guard`

## Requirements
- R1: The array is split into four equal quarters by the two top address bits below the array depth. `lock_lvl_i` = 2'b00 locks nothing, 2'b01 locks quarter 3 (the highest addresses), 2'b10 locks quarters 2 and 3, and 2'b11 locks all four. `arr_locked_o` reports whether the target address is locked.
- R2: `hw_prot_o` is 1 exactly when `prot_pin_i` is 0 and `lock_en_i` is 1. While it is 1, `sr_grant_o` is 0.
- R3: While the write-enable latch (`wr_latch_o`) is 0, both `sr_grant_o` and `arr_grant_o` are 0, whatever the other inputs.
- R4: While the latch is 1, `arr_grant_o` equals the inverse of `arr_locked_o`, independent of `prot_pin_i` and `lock_en_i`.
- R5: A clock edge with `op_valid_i`=1 and `op_code_i`=8'h06 sets the latch. With 8'h04 it clears the latch. Any other code leaves the latch unchanged. The latch output changes one clock edge after the opcode is presented.
- R6: An active-low `rst_n` clears the latch asynchronously, and the latch reads 0 after reset.
- R7: A clock edge with `cycle_done_i`=1 clears the latch, and this has priority over a set opcode presented on the same edge.
- R8: While `sel_n_i` is 0, `sr_wr_seq_i` is 1 and `lock_en_i` is 1, a fall of `prot_pin_i` between two clock edges sets `sr_abort_o`. `sr_abort_o` then forces `sr_grant_o` to 0 even if the pin rises again. A clock edge with `sel_n_i`=1 clears `sr_abort_o`.
- R9: A pin fall while `lock_en_i` is 0, or while `sel_n_i` is 1 (the internal cycle is already running), does not set `sr_abort_o`.
- R10: Address bits at and above log2(DEPTH) are ignored for region decoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| op_valid_i | input | 1 | Decoded opcode byte is valid this cycle |
| op_code_i | input | 8 | Opcode byte |
| cycle_done_i | input | 1 | Pulse when a program cycle completes |
| prot_pin_i | input | 1 | Write-protect pin, 0 = protect |
| lock_en_i | input | 1 | Stored enable bit for the protect pin |
| lock_lvl_i | input | 2 | Stored region lock level |
| sel_n_i | input | 1 | Chip select, active low |
| sr_wr_seq_i | input | 1 | A status-register write sequence is being received |
| tgt_addr_i | input | ADDR_W | Target byte address |
| wr_latch_o | output | 1 | Write-enable latch state |
| hw_prot_o | output | 1 | Hardware protection active |
| arr_locked_o | output | 1 | Target address is in a locked region |
| arr_grant_o | output | 1 | Array write allowed |
| sr_grant_o | output | 1 | Status-register write allowed |
| sr_abort_o | output | 1 | Current status-register write was cancelled by the pin |

## Verification
The grant logic is driven through every combination of pin, enable bit, latch and lock level. At each combination it is probed at the first and last byte of each quarter. This separates an off-by-one boundary from a wrong quarter, and it shows whether pin or enable leak into array grants. Addresses with upper bits set show whether those bits are excluded. The latch is checked with set, clear and unrelated opcodes, and with completion on the same edge as a set, which exposes the clear-over-set priority. The abort path is checked three ways: a pin fall with the enable on, one with the enable off, and one with chip select released. A pin that rises again before deselect shows that the abort is held rather than recomputed.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
   typedef enum logic [1:0] {
      LOCK_NONE = 2'b00,
      LOCK_QTR  = 2'b01,
      LOCK_HALF = 2'b10,
      LOCK_ALL  = 2'b11
   } lock_lvl_e;

   localparam logic [7:0] OP_LATCH_SET = 8'h06;
   localparam logic [7:0] OP_LATCH_CLR = 8'h04;
endpackage

// File: rtl/wpg_region_dec.sv
module wpg_region_dec #(
   parameter int DEPTH        = 8192,
   parameter int DECODE_STYLE = 0
) (
   input  logic [$clog2(DEPTH)-1:0] addr_i,
   input  logic [1:0]               lvl_i,
   output logic                     locked_o
);
   import wpg_pkg::*;
   localparam int AW  = $clog2(DEPTH);
   localparam int AW1 = AW + 1;

   generate
      if (DEPTH != 1024 && DEPTH != 2048 && DEPTH != 4096 && DEPTH != 8192) begin : g_bad_depth
         $error("wpg_region_dec: DEPTH must be 1024, 2048, 4096 or 8192");
      end
      if (DECODE_STYLE != 0 && DECODE_STYLE != 1) begin : g_bad_style
         $error("wpg_region_dec: DECODE_STYLE must be 0 or 1");
      end
   endgenerate

   lock_lvl_e lvl;
   assign lvl = lock_lvl_e'(lvl_i);

   generate
      if (DECODE_STYLE == 0) begin : g_quarter_bits
         logic [1:0] quarter;
         assign quarter = addr_i[AW-1:AW-2];
         always_comb begin
            unique case (lvl)
               LOCK_NONE: locked_o = 1'b0;
               LOCK_QTR:  locked_o = (quarter == 2'b11);
               LOCK_HALF: locked_o = quarter[1];
               default:   locked_o = 1'b1;
            endcase
         end
      end else begin : g_threshold
         logic [AW:0] base;
         always_comb begin
            unique case (lvl)
               LOCK_NONE: base = AW1'(DEPTH);
               LOCK_QTR:  base = AW1'((DEPTH / 4) * 3);
               LOCK_HALF: base = AW1'(DEPTH / 2);
               default:   base = '0;
            endcase
         end
         assign locked_o = ({1'b0, addr_i} >= base);
      end
   endgenerate
endmodule

// File: rtl/wpg_enable_latch.sv
module wpg_enable_latch (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       op_valid_i,
   input  logic [7:0] op_code_i,
   input  logic       done_i,
   output logic       latch_o
);
   import wpg_pkg::*;

   logic latch_q;
   logic is_set;
   logic is_clr;

   assign is_set = op_valid_i && (op_code_i == OP_LATCH_SET);
   assign is_clr = op_valid_i && (op_code_i == OP_LATCH_CLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       latch_q <= 1'b0;
      else if (done_i)  latch_q <= 1'b0;
      else if (is_set)  latch_q <= 1'b1;
      else if (is_clr)  latch_q <= 1'b0;
   end

   assign latch_o = latch_q;

   // R7
   done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> !latch_o);

   // R5
   set_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && op_code_i == 8'h06 && !done_i) |=> latch_o);

   // R5
   other_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_i && !(op_valid_i && (op_code_i == 8'h06 || op_code_i == 8'h04)))
      |=> $stable(latch_o));
endmodule

// File: rtl/wpg_abort_mon.sv
module wpg_abort_mon (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic lock_en_i,
   input  logic sel_n_i,
   input  logic sr_seq_i,
   output logic abort_o
);
   logic pin_q;
   logic abort_q;
   logic pin_fell;

   assign pin_fell = pin_q && !pin_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q   <= 1'b1;
         abort_q <= 1'b0;
      end else begin
         pin_q <= pin_i;
         if (sel_n_i)
            abort_q <= 1'b0;
         else if (sr_seq_i && lock_en_i && pin_fell)
            abort_q <= 1'b1;
      end
   end

   assign abort_o = abort_q;

   // R8
   deselect_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n_i |=> !abort_o);

   // R9
   no_abort_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!abort_o && !lock_en_i) |=> !abort_o);
endmodule

// File: rtl/wpg_grant.sv
module wpg_grant (
   input  logic latch_i,
   input  logic pin_i,
   input  logic lock_en_i,
   input  logic locked_i,
   input  logic abort_i,
   output logic hw_prot_o,
   output logic sr_grant_o,
   output logic arr_grant_o
);
   always_comb begin
      hw_prot_o   = lock_en_i && !pin_i;
      sr_grant_o  = latch_i && !hw_prot_o && !abort_i;
      arr_grant_o = latch_i && !locked_i;
   end
endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
   parameter int DEPTH        = 8192,
   parameter int ADDR_W       = 16,
   parameter int DECODE_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid_i,
   input  logic [7:0]        op_code_i,
   input  logic              cycle_done_i,
   input  logic              prot_pin_i,
   input  logic              lock_en_i,
   input  logic [1:0]        lock_lvl_i,
   input  logic              sel_n_i,
   input  logic              sr_wr_seq_i,
   input  logic [ADDR_W-1:0] tgt_addr_i,
   output logic              wr_latch_o,
   output logic              hw_prot_o,
   output logic              arr_locked_o,
   output logic              arr_grant_o,
   output logic              sr_grant_o,
   output logic              sr_abort_o
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (ADDR_W <= AW) begin : g_bad_addr_w
         $error("wp_guard: ADDR_W must exceed log2(DEPTH)");
      end
   endgenerate

   logic          latch;
   logic          locked;
   logic          abort;
   logic [AW-1:0] addr_lo;
   logic          unused_addr_hi;

   assign addr_lo        = tgt_addr_i[AW-1:0];
   assign unused_addr_hi = ^tgt_addr_i[ADDR_W-1:AW];

   wpg_enable_latch u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_valid_i (op_valid_i),
      .op_code_i  (op_code_i),
      .done_i     (cycle_done_i),
      .latch_o    (latch)
   );

   wpg_region_dec #(.DEPTH(DEPTH), .DECODE_STYLE(DECODE_STYLE)) u_region (
      .addr_i   (addr_lo),
      .lvl_i    (lock_lvl_i),
      .locked_o (locked)
   );

   wpg_abort_mon u_abort (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (prot_pin_i),
      .lock_en_i (lock_en_i),
      .sel_n_i   (sel_n_i),
      .sr_seq_i  (sr_wr_seq_i),
      .abort_o   (abort)
   );

   wpg_grant u_grant (
      .latch_i     (latch),
      .pin_i       (prot_pin_i),
      .lock_en_i   (lock_en_i),
      .locked_i    (locked),
      .abort_i     (abort),
      .hw_prot_o   (hw_prot_o),
      .sr_grant_o  (sr_grant_o),
      .arr_grant_o (arr_grant_o)
   );

   assign wr_latch_o   = latch;
   assign arr_locked_o = locked;
   assign sr_abort_o   = abort;

   // R3
   latch_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_grant_o || arr_grant_o) |-> wr_latch_o);

   // R4
   locked_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_locked_o |-> !arr_grant_o);

   // R2
   hw_blocks_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!prot_pin_i && lock_en_i) |-> !sr_grant_o);

   // R1
   lock_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_lvl_i == 2'b11) |-> arr_locked_o);

   // R8
   abort_blocks_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sr_abort_o |-> !sr_grant_o);
endmodule

// File: tb/wp_guard_test.sv
module wp_guard_test;
   localparam int DEPTH  = 8192;
   localparam int ADDR_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              op_valid = 1'b0;
   logic [7:0]        op_code = 8'h00;
   logic              cycle_done = 1'b0;
   logic              prot_pin = 1'b1;
   logic              lock_en = 1'b0;
   logic [1:0]        lock_lvl = 2'b00;
   logic              sel_n = 1'b1;
   logic              sr_seq = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic wr_latch, hw_prot, arr_locked, arr_grant, sr_grant, sr_abort;

   int n_run  = 0;
   int n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   wp_guard #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uut (
      .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_code_i(op_code),
      .cycle_done_i(cycle_done), .prot_pin_i(prot_pin), .lock_en_i(lock_en),
      .lock_lvl_i(lock_lvl), .sel_n_i(sel_n), .sr_wr_seq_i(sr_seq),
      .tgt_addr_i(addr), .wr_latch_o(wr_latch), .hw_prot_o(hw_prot),
      .arr_locked_o(arr_locked), .arr_grant_o(arr_grant),
      .sr_grant_o(sr_grant), .sr_abort_o(sr_abort)
   );

   task automatic check(string req, logic act, logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b", req, act, exp);
      end
   endtask

   function automatic logic ref_locked(logic [1:0] lvl, int q);
      return (lvl == 2'b11) || (lvl == 2'b10 && q >= 2) || (lvl == 2'b01 && q == 3);
   endfunction

   task automatic send_op(logic [7:0] code, logic done);
      @(negedge clk);
      op_valid = 1'b1; op_code = code; cycle_done = done;
      @(negedge clk);
      op_valid = 1'b0; cycle_done = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R6 latch after reset", wr_latch, 1'b0);
      check("R6 abort after reset", sr_abort, 1'b0);
      check("R3 sr grant after reset", sr_grant, 1'b0);
      send_op(8'h06, 1'b0);
      check("R5 set before async reset", wr_latch, 1'b1);
      #1 rst_n = 1'b0;
      #1 check("R6 async clear", wr_latch, 1'b0);
      @(negedge clk) rst_n = 1'b1;
   endtask

   task automatic t_latch_ops();
      send_op(8'h05, 1'b0);
      check("R5 other code from 0", wr_latch, 1'b0);
      send_op(8'h06, 1'b0);
      check("R5 set opcode", wr_latch, 1'b1);
      send_op(8'h02, 1'b0);
      check("R5 other code from 1", wr_latch, 1'b1);
      send_op(8'h04, 1'b0);
      check("R5 clear opcode", wr_latch, 1'b0);
   endtask

   task automatic t_done();
      send_op(8'h06, 1'b0);
      send_op(8'h00, 1'b1);
      check("R7 completion clears", wr_latch, 1'b0);
      send_op(8'h06, 1'b1);
      check("R7 completion beats set", wr_latch, 1'b0);
   endtask

   task automatic t_sweep();
      for (int lat = 0; lat < 2; lat++) begin
         send_op(lat ? 8'h06 : 8'h04, 1'b0);
         for (int pin = 0; pin < 2; pin++)
            for (int en = 0; en < 2; en++)
               for (int lvl = 0; lvl < 4; lvl++)
                  for (int q = 0; q < 4; q++)
                     for (int e = 0; e < 2; e++) begin
                        logic lk, hp;
                        prot_pin = pin[0]; lock_en = en[0]; lock_lvl = lvl[1:0];
                        addr = ADDR_W'(q * (DEPTH / 4) + (e ? DEPTH / 4 - 1 : 0));
                        #1;
                        lk = ref_locked(lvl[1:0], q);
                        hp = (pin == 0) && (en == 1);
                        check("R1 region lock", arr_locked, lk);
                        check("R2 hw protect flag", hw_prot, hp);
                        check("R3/R2 status grant", sr_grant, lat[0] && !hp);
                        check("R4/R3 array grant", arr_grant, lat[0] && !lk);
                     end
      end
      prot_pin = 1'b1; lock_en = 1'b0;
   endtask

   task automatic t_wrap();
      send_op(8'h06, 1'b0);
      lock_lvl = 2'b01;
      addr = 16'hE000 | 16'(DEPTH - 1);
      #1 check("R10 upper bits, top byte", arr_locked, 1'b1);
      addr = 16'hE000;
      #1 check("R10 upper bits, byte 0", arr_locked, 1'b0);
      check("R10 grant with upper bits", arr_grant, 1'b1);
      lock_lvl = 2'b00;
   endtask

   task automatic t_abort();
      send_op(8'h06, 1'b0);
      lock_en = 1'b1; prot_pin = 1'b1; sel_n = 1'b0; sr_seq = 1'b1;
      @(negedge clk);
      check("R8 grant before fall", sr_grant, 1'b1);
      prot_pin = 1'b0;
      @(negedge clk);
      prot_pin = 1'b1;
      #1 check("R8 abort set", sr_abort, 1'b1);
      check("R8 grant held off", sr_grant, 1'b0);
      @(negedge clk);
      check("R8 abort holds", sr_abort, 1'b1);
      sel_n = 1'b1;
      @(negedge clk);
      check("R8 deselect clears", sr_abort, 1'b0);
      check("R8 grant back", sr_grant, 1'b1);
      lock_en = 1'b0; sel_n = 1'b0;
      @(negedge clk) prot_pin = 1'b0;
      @(negedge clk) prot_pin = 1'b1;
      #1 check("R9 no abort with enable off", sr_abort, 1'b0);
      check("R9 grant with enable off", sr_grant, 1'b1);
      lock_en = 1'b1; sel_n = 1'b1;
      @(negedge clk) prot_pin = 1'b0;
      @(negedge clk) prot_pin = 1'b1;
      #1 check("R9 no abort when deselected", sr_abort, 1'b0);
      sr_seq = 1'b0; lock_en = 1'b0;
   endtask

   initial begin
      #12 rst_n = 1'b1;
      t_reset();
      t_latch_ops();
      t_done();
      t_sweep();
      t_wrap();
      t_abort();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #500000;
      if (!finished) begin
         finished = 1;
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule